// File: doc/BRIEF.md
# Serial Three-Bit Combination Lock

This controller decides whether a key, typed one bit at a time, matches a combination held in register bits outside the block. The operator first pulses the restart input. Then, for each key bit, the operator sets the key switch and presses the enter button. After the last bit the controller raises either the open indication or the reject indication. That indication stays on until the next restart.

A wrong bit does not stop the sequence early. Once a bit mismatches, the controller moves onto a separate "already wrong" track. It still takes the remaining enter presses, so it reports the reject only after the full key length. An observer therefore cannot tell from the outputs which bit was wrong. The enter button is edge-detected, so a press held over many clocks counts as one bit. The key length is a parameter. Its default of three gives the usual three-bit lock.

Top module: `serial_key_lock`

## Requirements
- R1: After the asynchronous reset is released, `unlock` and `error` are both 0.
- R2: When every entered bit matches its combination bit, `unlock` goes to 1 on the clock edge that takes the last enter press, and `error` stays 0.
- R3: Bits are compared in entry order. The first press is compared with `combo[0]`, the second with `combo[1]` and the third with `combo[2]`.
- R4: After any mismatch, `unlock` and `error` both stay 0 until the last bit has been entered. `error` goes to 1 on the clock edge that takes the last press.
- R5: An enter level held high for several clocks counts as exactly one bit. A bit is taken only on a 0-to-1 change of `enter` seen at a clock edge.
- R6: `restart` high at a clock edge returns the controller to its first bit from any state. It clears `unlock` and `error` on that edge, and it takes priority over a press in the same cycle.
- R7: Once `unlock` or `error` is 1, it holds its value until a restart. Further enter presses and changes to `key_bit` have no effect on it.
- R8: `unlock` and `error` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| restart | input | 1 | Synchronous operator restart: returns to the first bit |
| enter | input | 1 | Enter button level; its rising edge takes one key bit |
| key_bit | input | 1 | Key bit switch, sampled at the enter edge |
| combo | input | KEY_LEN | Stored combination; bit i is compared with the i-th entry |
| unlock | output | 1 | Registered: the full key matched |
| error | output | 1 | Registered: the full key was entered with at least one mismatch |

## Verification
The outputs are the only view into the state, so a wrong state shows up at the completion of a sequence. Examples are a bit index that advances twice on a held press, a mismatch flag that is lost, or a track that does not pass through restart. Each of these turns into an early, late or inverted `unlock`/`error` on the edge that should take the last bit. That edge is at most three presses after the fault. Directed sequences put a mismatch at each bit position. Random sessions mix held presses, restarts in the middle of a sequence and extra presses after completion. Together they make every such fault visible within one sequence.

// File: rtl/serial_key_lock_pkg.sv
package serial_key_lock_pkg;
  typedef enum logic [1:0] {
    ST_MATCH = 2'd0,
    ST_WRONG = 2'd1,
    ST_OPEN  = 2'd2,
    ST_FAIL  = 2'd3
  } lock_state_e;
endpackage

// File: rtl/lock_press_edge.sv
module lock_press_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign pulse = level & ~level_d;
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import serial_key_lock_pkg::*;
#(
  parameter int KEY_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               press,
  input  logic               key_bit,
  input  logic [KEY_LEN-1:0] combo,
  output lock_state_e        state_nx_o,
  output logic               upd_o
);
  localparam int IDX_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);

  lock_state_e       state_q, state_nx;
  logic [IDX_W-1:0]  idx_q, idx_nx;
  logic [KEY_LEN-1:0] hit_vec;
  logic              hit, last, upd;

  for (genvar i = 0; i < KEY_LEN; i++) begin : g_cmp
    assign hit_vec[i] = (combo[i] == key_bit);
  end

  assign hit  = hit_vec[idx_q];
  assign last = (idx_q == LAST_IDX);
  assign upd  = restart | press;

  always_comb begin
    state_nx = state_q;
    idx_nx   = idx_q;
    if (restart) begin
      state_nx = ST_MATCH;
      idx_nx   = '0;
    end else if (press) begin
      unique case (state_q)
        ST_MATCH: begin
          if (last) state_nx = hit ? ST_OPEN : ST_FAIL;
          else begin
            state_nx = hit ? ST_MATCH : ST_WRONG;
            idx_nx   = idx_q + 1'b1;
          end
        end
        ST_WRONG: begin
          if (last) state_nx = ST_FAIL;
          else      idx_nx   = idx_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_MATCH;
      idx_q   <= '0;
    end else if (upd) begin
      state_q <= state_nx;
      idx_q   <= idx_nx;
    end
  end

  assign state_nx_o = state_nx;
  assign upd_o      = upd;
endmodule

// File: rtl/lock_out_reg.sv
module lock_out_reg
  import serial_key_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  lock_state_e state_nx,
  output logic        unlock,
  output logic        error
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock <= 1'b0;
      error  <= 1'b0;
    end else if (en) begin
      unlock <= (state_nx == ST_OPEN);
      error  <= (state_nx == ST_FAIL);
    end
  end
endmodule

// File: rtl/serial_key_lock.sv
module serial_key_lock
  import serial_key_lock_pkg::*;
#(
  parameter int KEY_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               enter,
  input  logic               key_bit,
  input  logic [KEY_LEN-1:0] combo,
  output logic               unlock,
  output logic               error
);
  logic        press;
  logic        upd;
  lock_state_e state_nx;

  lock_press_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (enter),
    .pulse (press)
  );

  lock_seq_fsm #(.KEY_LEN(KEY_LEN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .press      (press),
    .key_bit    (key_bit),
    .combo      (combo),
    .state_nx_o (state_nx),
    .upd_o      (upd)
  );

  lock_out_reg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (upd),
    .state_nx (state_nx),
    .unlock   (unlock),
    .error    (error)
  );
endmodule

// File: rtl/serial_key_lock_chk.sv
module serial_key_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic enter,
  input logic unlock,
  input logic error
);
  // R8
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlock && error));

  // R7
  unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !restart) |=> unlock);

  // R7
  error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !restart) |=> error);

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!unlock && !error));

  // R2
  unlock_on_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock) |-> ($past(enter) && !$past(restart)));

  // R4
  error_on_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> ($past(enter) && !$past(restart)));
endmodule

bind serial_key_lock serial_key_lock_chk u_chk (.*);

// File: tb/sim_serial_key_lock.sv
module sim_serial_key_lock;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_LEN    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic enter = 1'b0;
  logic key_bit = 1'b0;
  logic [KEY_LEN-1:0] combo = '0;
  logic unlock, error;

  int n_chk = 0;
  int n_fail = 0;

  int m_idx;
  bit m_bad, m_u, m_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_key_lock #(.KEY_LEN(KEY_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .enter(enter),
    .key_bit(key_bit), .combo(combo), .unlock(unlock), .error(error)
  );

  task automatic chk(input string req, input logic eu, input logic ee);
    n_chk++;
    if (unlock !== eu || error !== ee) begin
      n_fail++;
      $display("FAIL %s: unlock/error actual %b%b expected %b%b", req, unlock, error, eu, ee);
    end
  endtask

  function automatic void model_clear();
    m_idx = 0; m_bad = 0; m_u = 0; m_e = 0;
  endfunction

  function automatic void model_press(input logic kb);
    if (m_u || m_e) return;
    if (kb != combo[m_idx]) m_bad = 1;
    if (m_idx == KEY_LEN - 1) begin
      m_u = !m_bad;
      m_e = m_bad;
    end else m_idx++;
  endfunction

  task automatic do_restart(input string req);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    model_clear();
    chk(req, 1'b0, 1'b0);
  endtask

  task automatic press(input logic kb, input int hold, input string req);
    key_bit = kb;
    enter   = 1'b1;
    model_press(kb);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      key_bit = $urandom_range(0, 1);
      chk(req, m_u, m_e);
    end
    enter = 1'b0;
    @(negedge clk);
    chk(req, m_u, m_e);
  endtask

  task automatic enter_key(input logic [KEY_LEN-1:0] k, input string req);
    for (int i = 0; i < KEY_LEN; i++) press(k[i], 1, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, 1'b0);

    // R2 / R3: correct key, asymmetric combination
    combo = 3'b001;
    do_restart("R6");
    enter_key(3'b001, "R2");
    // R3: reversed order must be rejected
    do_restart("R6");
    enter_key(3'b100, "R3");
    chk("R3", 1'b0, 1'b1);

    // R4: mismatch at each position, no early error
    combo = 3'b110;
    for (int p = 0; p < KEY_LEN; p++) begin
      do_restart("R6");
      for (int i = 0; i < KEY_LEN; i++) begin
        press(combo[i] ^ (i == p), 1, "R4");
        if (i < KEY_LEN - 1) chk("R4", 1'b0, 1'b0);
      end
      chk("R4", 1'b0, 1'b1);
    end

    // R5: long hold counts once
    combo = 3'b011;
    do_restart("R6");
    press(1'b1, 6, "R5");
    chk("R5", 1'b0, 1'b0);
    press(1'b1, 1, "R5");
    chk("R5", 1'b0, 1'b0);
    press(1'b0, 1, "R5");
    chk("R5", 1'b1, 1'b0);

    // R7: presses after completion ignored
    press(1'b1, 1, "R7");
    press(1'b0, 3, "R7");
    chk("R7", 1'b1, 1'b0);

    // R6: restart wins over a simultaneous press
    do_restart("R6");
    key_bit = 1'b1; enter = 1'b1; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0; enter = 1'b0;
    @(negedge clk);
    chk("R6", 1'b0, 1'b0);
    enter_key(3'b011, "R6");
    chk("R6", 1'b1, 1'b0);

    // random sessions
    for (int s = 0; s < 400; s++) begin
      logic [KEY_LEN-1:0] k;
      combo = KEY_LEN'($urandom);
      k = ($urandom_range(0, 1) == 1) ? combo : (combo ^ KEY_LEN'($urandom));
      do_restart("R6");
      for (int i = 0; i < KEY_LEN; i++) begin
        if ($urandom_range(0, 15) == 0) do_restart("R6");
        press(k[i], $urandom_range(1, 3), "R2/R4");
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          chk("R5", m_u, m_e);
        end
      end
      for (int e = 0; e < int'($urandom_range(0, 2)); e++)
        press($urandom_range(0, 1), 1, "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule